// File: doc/BRIEF.md
# Two-Bank Edge Interrupt Collector

This block gathers up to 64 edge-sensitive request lines (55 by default) into two 32-bit banks of sticky pending bits. Each line is compared with its value from the previous clock. A transition in the direction chosen for that line marks the line pending. The bit stays pending until software writes a one to it. Software can also force pending bits with a set register. An enable mask decides which pending bits drive the single host interrupt line.

A second, independent path produces a wake request. A per-line wake mask and a per-line wake level select the lines that ask for wake-up. The host reaches every register through a plain word-wide port, with a write strobe and a combinational read mux. Three extra registers are plain storage with no effect on the logic.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, and both `irq_o` and `wake_o` are low.
- R2: With its edge-select bit at 0, a low-to-high change on a source marks its pending bit. The bit stays set until it is cleared.
- R3: A write to the pending register of a bank (byte offset 0x1C for bank 0, 0x20 for bank 1) clears every bit written as 1. Bits written as 0 keep their value. A read of the same offset returns the pending bits.
- R4: `irq_o` is a registered OR of pending AND enabled bits. The enable registers sit at 0x08 and 0x0C. `irq_o` follows a change one clock after the pending or enable register changes.
- R5: The edge-select registers are at 0x10 and 0x14. A bit set to 1 makes only high-to-low changes of that source count. Low-to-high changes are then ignored.
- R6: Writing ones to a force register (0x24 for bank 0, 0x28 for bank 1) marks those pending bits. The force registers always read as zero.
- R7: If a qualifying edge and a clear hit the same bit in one cycle, the bit stays pending.
- R8: Source n below 32 maps to bit n of bank 0. Source n of 32 or more maps to bit n−32 of bank 1. Bits 31..23 of every bank-1 register read zero and ignore writes.
- R9: `wake_o` is high one clock after any source enabled in the wake mask (0x2C/0x30) sits at its wake level. The wake level is set at 0x34/0x38, where 0 means high and 1 means low. The wake path ignores the interrupt enables.
- R10: The words at 0x00, 0x04 and 0x18 read back what was written. Writing them changes no pending bit and no output.
- R11: Clearing both pending registers with all ones while both enables are zero leaves no pending bit and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_SRC | Request lines, sampled every clock |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | ADDR_W | Byte offset of the addressed word |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Host interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
Assertions check several rules on every clock:
- A pending bit never drops without a clear write.
- Every qualifying edge, and every forced bit, shows up as pending, even against a clear in the same cycle.
- A cleared bit with no new event is gone on the next clock.
- `irq_o` and `wake_o` follow their registered terms.
- The upper bank-1 bits read zero.

Only the bench scenarios can show the rest:
- the address map itself
- the behaviour of each edge-select setting
- the partial clears
- the round trip through the storage-only words
- the quiet state after the full clear

// File: rtl/eic_pkg.sv
package eic_pkg;
  // Byte offsets of the register words; the host driver depends on them.
  localparam int OFF_SPARE0 = 'h00;
  localparam int OFF_SPARE1 = 'h04;
  localparam int OFF_ENA    = 'h08;  // + 4 * bank
  localparam int OFF_EDGE   = 'h10;  // + 4 * bank
  localparam int OFF_SPARE2 = 'h18;
  localparam int OFF_PEND   = 'h1C;  // + 4 * bank
  localparam int OFF_FORCE  = 'h24;  // + 4 * bank
  localparam int OFF_WKEN   = 'h2C;  // + 4 * bank
  localparam int OFF_WKLVL  = 'h34;  // + 4 * bank
  localparam int NUM_BANKS  = 2;
  localparam int BANK_BITS  = 32;

  function automatic int bank_width(int nsrc, int bank);
    int rest;
    rest = nsrc - bank * BANK_BITS;
    return (rest > BANK_BITS) ? BANK_BITS : rest;
  endfunction
endpackage

// File: rtl/eic_rst_sync.sv
module eic_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/eic_word_reg.sv
module eic_word_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (we_i) q_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/eic_bank.sv
module eic_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] wdata_i,
  input  logic         wr_ena_i,
  input  logic         wr_edge_i,
  input  logic         wr_clr_i,
  input  logic         wr_force_i,
  input  logic         wr_wken_i,
  input  logic         wr_wklvl_i,
  output logic [W-1:0] ena_o,
  output logic [W-1:0] edge_sel_o,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] wken_o,
  output logic [W-1:0] wklvl_o,
  output logic         irq_hit_o,
  output logic         wake_hit_o
);
  logic [W-1:0] ena_q, edge_sel_q, wken_q, wklvl_q;
  logic [W-1:0] pend_d, pend_q, src_q;
  logic [W-1:0] rise_v, fall_v, hit_v, clr_v, force_v;

  eic_word_reg #(.W(W)) ena_reg_i   (.clk_i, .rst_ni, .we_i(wr_ena_i),   .d_i(wdata_i), .q_o(ena_q));
  eic_word_reg #(.W(W)) edge_reg_i  (.clk_i, .rst_ni, .we_i(wr_edge_i),  .d_i(wdata_i), .q_o(edge_sel_q));
  eic_word_reg #(.W(W)) wken_reg_i  (.clk_i, .rst_ni, .we_i(wr_wken_i),  .d_i(wdata_i), .q_o(wken_q));
  eic_word_reg #(.W(W)) wklvl_reg_i (.clk_i, .rst_ni, .we_i(wr_wklvl_i), .d_i(wdata_i), .q_o(wklvl_q));

  always_comb begin
    rise_v  = src_i & ~src_q;
    fall_v  = ~src_i & src_q;
    hit_v   = (rise_v & ~edge_sel_q) | (fall_v & edge_sel_q);
    clr_v   = wr_clr_i   ? wdata_i : '0;
    force_v = wr_force_i ? wdata_i : '0;
    // new events are applied after the clear, so they win a collision
    pend_d  = (pend_q & ~clr_v) | hit_v | force_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      src_q  <= '0;
    end else begin
      pend_q <= pend_d;
      src_q  <= src_i;
    end
  end

  assign ena_o      = ena_q;
  assign edge_sel_o = edge_sel_q;
  assign pend_o     = pend_q;
  assign wken_o     = wken_q;
  assign wklvl_o    = wklvl_q;
  assign irq_hit_o  = |(pend_q & ena_q);
  assign wake_hit_o = |(wken_q & (src_i ^ wklvl_q));

  // R2
  sticky_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_clr_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R2 R7
  edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past((src_i & ~src_q & ~edge_sel_q) | (~src_i & src_q & edge_sel_q)))
              == $past((src_i & ~src_q & ~edge_sel_q) | (~src_i & src_q & edge_sel_q))));

  // R6
  force_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_force_i |=> ((pend_q & $past(wdata_i)) == $past(wdata_i)));

  // R3
  clear_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr_i && !wr_force_i && (src_i == src_q)) |=> ((pend_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_SRC = 55,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o,
  output logic               wake_o
);
  localparam int NB = NUM_BANKS;

  logic rst_s_n;
  logic [DATA_W-1:0] ena_all   [NB];
  logic [DATA_W-1:0] edge_all  [NB];
  logic [DATA_W-1:0] pend_all  [NB];
  logic [DATA_W-1:0] wken_all  [NB];
  logic [DATA_W-1:0] wklvl_all [NB];
  logic [NB-1:0] irq_hit, wake_hit;
  logic [DATA_W-1:0] spare0_q, spare1_q, spare2_q;
  logic irq_d, irq_q, wake_d, wake_q;

  eic_rst_sync rst_sync_i (.clk_i, .rst_ni, .rst_sync_no(rst_s_n));

  function automatic logic hit_addr(logic [ADDR_W-1:0] a, int off);
    return a == ADDR_W'(off);
  endfunction

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int LO = b * BANK_BITS;
    localparam int W  = bank_width(NUM_SRC, b);
    logic [W-1:0] ena_w, edge_w, pend_w, wken_w, wklvl_w;

    eic_bank #(.W(W)) bank_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_s_n),
      .src_i      (src_i[LO +: W]),
      .wdata_i    (reg_wdata_i[W-1:0]),
      .wr_ena_i   (reg_wr_i && hit_addr(reg_addr_i, OFF_ENA   + 4*b)),
      .wr_edge_i  (reg_wr_i && hit_addr(reg_addr_i, OFF_EDGE  + 4*b)),
      .wr_clr_i   (reg_wr_i && hit_addr(reg_addr_i, OFF_PEND  + 4*b)),
      .wr_force_i (reg_wr_i && hit_addr(reg_addr_i, OFF_FORCE + 4*b)),
      .wr_wken_i  (reg_wr_i && hit_addr(reg_addr_i, OFF_WKEN  + 4*b)),
      .wr_wklvl_i (reg_wr_i && hit_addr(reg_addr_i, OFF_WKLVL + 4*b)),
      .ena_o      (ena_w),
      .edge_sel_o (edge_w),
      .pend_o     (pend_w),
      .wken_o     (wken_w),
      .wklvl_o    (wklvl_w),
      .irq_hit_o  (irq_hit[b]),
      .wake_hit_o (wake_hit[b])
    );

    assign ena_all[b]   = DATA_W'(ena_w);
    assign edge_all[b]  = DATA_W'(edge_w);
    assign pend_all[b]  = DATA_W'(pend_w);
    assign wken_all[b]  = DATA_W'(wken_w);
    assign wklvl_all[b] = DATA_W'(wklvl_w);
  end

  eic_word_reg #(.W(DATA_W)) spare0_i (.clk_i, .rst_ni(rst_s_n),
    .we_i(reg_wr_i && hit_addr(reg_addr_i, OFF_SPARE0)), .d_i(reg_wdata_i), .q_o(spare0_q));
  eic_word_reg #(.W(DATA_W)) spare1_i (.clk_i, .rst_ni(rst_s_n),
    .we_i(reg_wr_i && hit_addr(reg_addr_i, OFF_SPARE1)), .d_i(reg_wdata_i), .q_o(spare1_q));
  eic_word_reg #(.W(DATA_W)) spare2_i (.clk_i, .rst_ni(rst_s_n),
    .we_i(reg_wr_i && hit_addr(reg_addr_i, OFF_SPARE2)), .d_i(reg_wdata_i), .q_o(spare2_q));

  always_comb begin
    reg_rdata_o = '0;
    if (hit_addr(reg_addr_i, OFF_SPARE0)) reg_rdata_o = spare0_q;
    if (hit_addr(reg_addr_i, OFF_SPARE1)) reg_rdata_o = spare1_q;
    if (hit_addr(reg_addr_i, OFF_SPARE2)) reg_rdata_o = spare2_q;
    for (int b = 0; b < NB; b++) begin
      if (hit_addr(reg_addr_i, OFF_ENA   + 4*b)) reg_rdata_o = ena_all[b];
      if (hit_addr(reg_addr_i, OFF_EDGE  + 4*b)) reg_rdata_o = edge_all[b];
      if (hit_addr(reg_addr_i, OFF_PEND  + 4*b)) reg_rdata_o = pend_all[b];
      if (hit_addr(reg_addr_i, OFF_WKEN  + 4*b)) reg_rdata_o = wken_all[b];
      if (hit_addr(reg_addr_i, OFF_WKLVL + 4*b)) reg_rdata_o = wklvl_all[b];
    end
  end

  always_comb begin
    irq_d  = |irq_hit;
    wake_d = |wake_hit;
  end

  always_ff @(posedge clk_i or negedge rst_s_n) begin
    if (!rst_s_n) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      wake_q <= wake_d;
    end
  end

  assign irq_o  = irq_q;
  assign wake_o = wake_q;

  // R4
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    1'b1 |=> (irq_o == $past(|irq_hit)));

  // R9
  wake_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    1'b1 |=> (wake_o == $past(|wake_hit)));

  // R8
  bank1_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (reg_addr_i == ADDR_W'(OFF_PEND + 4) || reg_addr_i == ADDR_W'(OFF_ENA + 4))
      |-> (reg_rdata_o[DATA_W-1:bank_width(NUM_SRC, 1)] == '0));
endmodule

// File: tb/edge_irq_ctrl_tb_top.sv
module edge_irq_ctrl_tb_top;
  localparam int N = 55;
  localparam logic [7:0] A_T0 = 8'h00, A_T1 = 8'h04, A_EN0 = 8'h08, A_EN1 = 8'h0C;
  localparam logic [7:0] A_POL0 = 8'h10, A_POL1 = 8'h14, A_TS = 8'h18;
  localparam logic [7:0] A_ST0 = 8'h1C, A_ST1 = 8'h20, A_SET0 = 8'h24, A_SET1 = 8'h28;
  localparam logic [7:0] A_WEN0 = 8'h2C, A_WPOL0 = 8'h34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic wr = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, wake;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  edge_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  // monitor: pops scoreboard items away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = (it.kind == 0) ? rdata : (it.kind == 1) ? {31'b0, irq} : {31'b0, wake};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic exp_read(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    tick();
  endtask

  task automatic exp_pin(input int k, input logic e, input string tag);
    item_t it;
    it.kind = k; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    tick();
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    exp_read(A_EN0, 32'h0, "R1 enable0");
    exp_read(A_ST0, 32'h0, "R1 pend0");
    exp_read(A_POL1, 32'h0, "R1 edge1");
    exp_pin(1, 1'b0, "R1 irq");
    exp_pin(2, 1'b0, "R1 wake");

    // R2 rising edge latches
    src[3] = 1'b1; tick();
    exp_read(A_ST0, 32'h8, "R2 rise pend");
    exp_read(A_ST0, 32'h8, "R2 sticky");
    // R4 enable drives irq one clock later
    exp_pin(1, 1'b0, "R4 masked");
    reg_write(A_EN0, 32'h8);
    exp_pin(1, 1'b0, "R4 delay");
    exp_pin(1, 1'b1, "R4 irq");
    // R3 clear
    reg_write(A_ST0, 32'h8);
    exp_read(A_ST0, 32'h0, "R3 cleared");
    exp_pin(1, 1'b0, "R4 irq drop");

    // R5 falling polarity
    reg_write(A_POL0, 32'h20);
    src[5] = 1'b1; tick();
    exp_read(A_ST0, 32'h0, "R5 rise ignored");
    src[5] = 1'b0; tick();
    exp_read(A_ST0, 32'h20, "R5 fall latched");
    reg_write(A_ST0, 32'hFFFF_FFFF);

    // R8 bank 1 mapping and width
    src[54] = 1'b1; tick();
    exp_read(A_ST1, 32'h0040_0000, "R8 src54");
    exp_read(A_ST0, 32'h0, "R8 bank0 untouched");
    reg_write(A_ST1, 32'hFFFF_FFFF);
    exp_read(A_ST1, 32'h0, "R3 bank1 cleared");
    reg_write(A_EN1, 32'hFFFF_FFFF);
    exp_read(A_EN1, 32'h007F_FFFF, "R8 upper ignored");

    // R6 force
    reg_write(A_SET1, 32'h1);
    exp_read(A_SET1, 32'h0, "R6 force reads zero");
    exp_read(A_ST1, 32'h1, "R6 forced");
    exp_pin(1, 1'b1, "R6 irq");
    reg_write(A_ST1, 32'hFFFF_FFFF);
    reg_write(A_EN1, 32'h0);
    tick();
    exp_pin(1, 1'b0, "R4 off");

    // R7 edge beats clear; R3 partial clear
    reg_write(A_SET0, 32'h1);
    exp_read(A_ST0, 32'h1, "R6 forced0");
    src[0] = 1'b1;
    reg_write(A_ST0, 32'h1);
    exp_read(A_ST0, 32'h1, "R7 edge wins");
    reg_write(A_ST0, 32'h1);
    exp_read(A_ST0, 32'h0, "R3 clear no edge");
    reg_write(A_SET0, 32'h3);
    reg_write(A_ST0, 32'h2);
    exp_read(A_ST0, 32'h1, "R3 zeros kept");
    reg_write(A_ST0, 32'hFFFF_FFFF);

    // R9 wake
    reg_write(A_WEN0, 32'h80);
    exp_pin(2, 1'b0, "R9 idle");
    src[7] = 1'b1; tick();
    exp_pin(2, 1'b1, "R9 high level");
    reg_write(A_WPOL0, 32'h80);
    tick();
    exp_pin(2, 1'b0, "R9 level inverted");
    src[7] = 1'b0; tick();
    exp_pin(2, 1'b1, "R9 low level");
    exp_pin(1, 1'b0, "R9 irq independent");
    reg_write(A_WEN0, 32'h0);
    tick();
    exp_pin(2, 1'b0, "R9 disabled");

    // R10 storage words
    reg_write(A_ST0, 32'hFFFF_FFFF);
    reg_write(A_T0, 32'hA5A5_A5A5);
    reg_write(A_T1, 32'h5A5A_5A5A);
    reg_write(A_TS, 32'hFFFF_FFFF);
    exp_read(A_T0, 32'hA5A5_A5A5, "R10 word0");
    exp_read(A_T1, 32'h5A5A_5A5A, "R10 word1");
    exp_read(A_TS, 32'hFFFF_FFFF, "R10 select");
    exp_read(A_ST0, 32'h0, "R10 no pend");
    exp_pin(1, 1'b0, "R10 irq");

    // R11 quiescent
    reg_write(A_EN0, 32'h0);
    reg_write(A_SET0, 32'hFF);
    reg_write(A_ST0, 32'hFFFF_FFFF);
    reg_write(A_ST1, 32'hFFFF_FFFF);
    tick();
    exp_read(A_ST0, 32'h0, "R11 pend0");
    exp_read(A_ST1, 32'h0, "R11 pend1");
    exp_pin(1, 1'b0, "R11 irq");

    tick();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule